// File: doc/BRIEF.md
# Direct-Mapped Cache with Exclusive Victim Buffer

This block is a direct-mapped first-level data cache backed by a small, fully associative buffer of recently displaced lines. Each processor access selects one cache line by its index bits. While that line's tag is compared, every victim entry is also searched by full line address. A hit in the main array answers on the next cycle. A hit in the victim buffer exchanges the two lines in one extra cycle, so a line is never held in both places. A miss in both fetches the line from memory. The displaced main-array line moves into the victim buffer, and if the buffer entry it replaces is dirty, that entry is first written back.

The processor presents one request at a time while `req_ready` is high and waits for `resp_valid`. The memory side moves whole lines through a request/acknowledge handshake. One line transfer is in flight at most.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req` are 0, and both structures are empty, so the first access to any line is a miss.
- R2: A byte address is split as offset (low log2(4*LINE_WORDS) bits, word select above the two byte bits), index (next log2(SETS) bits) and tag (the rest). Two lines with the same index but different tags cannot both sit in the main array.
- R3: A main-array hit raises `resp_valid` one cycle after the accepting edge, with `resp_kind` = 2'b01 and no memory traffic.
- R4: A victim-buffer hit answers two cycles after the accepting edge with `resp_kind` = 2'b10 and issues no memory request.
- R5: A miss in both reads the line at `mem_addr` = address[ADDR_W-1:log2(4*LINE_WORDS)] with `mem_we` = 0, answers with `resp_kind` = 2'b11, and pushes a valid displaced main-array line into the victim buffer.
- R6: A line is never present in both the main array and the victim buffer, and no two victim entries hold the same line. A swapped-out line is therefore found by a later victim hit.
- R7: An insertion fills an empty victim entry first. Otherwise it replaces the least recently used entry, where a swap or an insertion makes the written entry most recently used.
- R8: Replacing a dirty victim entry first writes its line to its own line address (`mem_we` = 1). Replacing a clean one writes nothing.
- R9: A write merges the bytes of `req_wdata` selected by `req_be` (bit b covers bits 8b+7:8b) into the addressed word. Every response returns the addressed word after the access. Written data survives swaps, evictions and write-backs.
- R10: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`. A read line is taken from `mem_rdata` in the acknowledge cycle.
- R11: While a swap or memory transfer is in progress, `req_ready` is 0 and requests are ignored. `resp_valid` only rises with `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte enables for writes |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_kind | output | 2 | 01 main hit, 10 victim hit, 11 miss |
| resp_rdata | output | 32 | Addressed word after the access |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = line fetch |
| mem_addr | output | ADDR_W-log2(4*LINE_WORDS) | Line address |
| mem_wdata | output | 32*LINE_WORDS | Write-back line |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | 32*LINE_WORDS | Fetched line |

## Verification
The bench builds the block with ADDR_W=10, LINE_WORDS=2, SETS=4 and VB_ENTRIES=3. A random working set of 16 lines then overflows both the four-line main array and the three-entry buffer within a few accesses. As a result, full-buffer LRU replacement, dirty write-backs and repeated swaps of the same lines occur thousands of times. Two-word lines keep the word select and the byte-enable merge on both halves of a line.

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 64,
  parameter int VB_ENTRIES = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_we,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [31:0]                req_wdata,
  input  logic [3:0]                 req_be,
  output logic                       req_ready,
  output logic                       resp_valid,
  output logic [1:0]                 resp_kind,
  output logic [31:0]                resp_rdata,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-$clog2(LINE_WORDS*4)-1:0] mem_addr,
  output logic [32*LINE_WORDS-1:0]   mem_wdata,
  input  logic                       mem_ack,
  input  logic [32*LINE_WORDS-1:0]   mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_WORDS*4);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int LINE_W = 32*LINE_WORDS;
  localparam int VB_W   = $clog2(VB_ENTRIES);

  typedef enum logic [1:0] {S_IDLE, S_SWAP, S_WB, S_FILL} state_t;
  typedef logic [VB_ENTRIES-1:0][VB_W-1:0] age_t;

  state_t state;
  logic [SETS-1:0] l1_v, l1_d;
  logic [SETS-1:0][TAG_W-1:0] l1_tag;
  logic [LINE_W-1:0] l1_data [SETS];
  logic [VB_ENTRIES-1:0] vb_v, vb_d;
  logic [VB_ENTRIES-1:0][LA_W-1:0] vb_la;
  logic [LINE_W-1:0] vb_data [VB_ENTRIES];
  age_t vb_age;

  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [31:0]       r_wdata;
  logic [3:0]        r_be;
  logic [VB_W-1:0]   slot;

  wire idle = state == S_IDLE;
  wire [LA_W-1:0] in_la = req_addr[ADDR_W-1:OFF_W];
  wire [LA_W-1:0] r_la  = r_addr[ADDR_W-1:OFF_W];
  wire [ADDR_W-1:0] a_addr = idle ? req_addr : r_addr;
  wire [IDX_W-1:0] a_idx  = a_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] a_tag  = a_addr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] a_wsel = a_addr[2 +: WSEL_W];
  wire a_we = idle ? req_we : r_we;
  wire [31:0] a_wdata = idle ? req_wdata : r_wdata;
  wire [3:0]  a_be = idle ? req_be : r_be;
  wire l1_hit = l1_v[a_idx] && l1_tag[a_idx] == a_tag;

  logic vb_hit;
  logic [VB_W-1:0] vb_hit_i, lru_i;
  always_comb begin
    vb_hit = 1'b0;
    vb_hit_i = '0;
    for (int i = 0; i < VB_ENTRIES; i++)
      if (vb_v[i] && vb_la[i] == in_la) begin
        vb_hit = 1'b1;
        vb_hit_i = VB_W'(i);
      end
  end

  always_comb begin
    lru_i = '0;
    for (int i = VB_ENTRIES-1; i >= 0; i--)
      if (vb_age[i] == VB_W'(VB_ENTRIES-1)) lru_i = VB_W'(i);
    for (int i = VB_ENTRIES-1; i >= 0; i--)
      if (!vb_v[i]) lru_i = VB_W'(i);
  end

  function automatic age_t touch(age_t age, logic [VB_ENTRIES-1:0] v,
                                 logic [VB_W-1:0] s, logic fresh);
    age_t res;
    for (int i = 0; i < VB_ENTRIES; i++)
      if (VB_W'(i) == s) res[i] = '0;
      else if (v[i] && (fresh || age[i] < age[s])) res[i] = age[i] + 1'b1;
      else res[i] = age[i];
    return res;
  endfunction

  logic [LINE_W-1:0] src_line, upd;
  always_comb begin
    src_line = idle ? l1_data[a_idx] : (state == S_SWAP) ? vb_data[slot] : mem_rdata;
    upd = src_line;
    for (int b = 0; b < 4; b++)
      if (a_we && a_be[b]) upd[32*a_wsel + 8*b +: 8] = a_wdata[8*b +: 8];
  end

  wire l1_wr = (idle && req_valid && l1_hit) || state == S_SWAP ||
               (state == S_FILL && mem_ack);
  wire vb_wr = state == S_SWAP || (state == S_FILL && mem_ack && l1_v[a_idx]);

  assign req_ready = idle;
  assign mem_req   = state == S_WB || state == S_FILL;
  assign mem_we    = state == S_WB;
  assign mem_addr  = mem_we ? vb_la[slot] : r_la;
  assign mem_wdata = vb_data[slot];

  always_ff @(posedge clk) begin
    if (l1_wr) begin
      l1_data[a_idx] <= upd;
      l1_tag[a_idx]  <= a_tag;
    end
    if (vb_wr) begin
      vb_data[slot] <= l1_data[a_idx];
      vb_la[slot]   <= {l1_tag[a_idx], a_idx};
    end
    if (idle && req_valid) begin
      r_we <= req_we; r_addr <= req_addr; r_wdata <= req_wdata; r_be <= req_be;
      slot <= vb_hit ? vb_hit_i : lru_i;
    end
    resp_rdata <= upd[32*a_wsel +: 32];
    resp_kind  <= idle ? 2'b01 : (state == S_SWAP) ? 2'b10 : 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      resp_valid <= 1'b0;
      l1_v <= '0; l1_d <= '0;
      vb_v <= '0; vb_d <= '0; vb_age <= '0;
    end else begin
      resp_valid <= l1_wr;
      case (state)
        S_IDLE: if (req_valid) begin
          if (l1_hit) l1_d[a_idx] <= l1_d[a_idx] | req_we;
          else if (vb_hit) state <= S_SWAP;
          else state <= (l1_v[a_idx] && vb_v[lru_i] && vb_d[lru_i]) ? S_WB : S_FILL;
        end
        S_SWAP: begin
          l1_d[a_idx] <= vb_d[slot] | r_we;
          vb_d[slot]  <= l1_d[a_idx];
          vb_v[slot]  <= l1_v[a_idx];
          vb_age      <= touch(vb_age, vb_v, slot, 1'b0);
          state       <= S_IDLE;
        end
        S_WB: if (mem_ack) state <= S_FILL;
        default: if (mem_ack) begin
          if (l1_v[a_idx]) begin
            vb_v[slot] <= 1'b1;
            vb_d[slot] <= l1_d[a_idx];
            vb_age     <= touch(vb_age, vb_v, slot, !vb_v[slot]);
          end
          l1_v[a_idx] <= 1'b1;
          l1_d[a_idx] <= r_we;
          state       <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dm_victim_cache_chk.sv
module dm_victim_cache_chk #(
  parameter int SETS = 64,
  parameter int VB_ENTRIES = 15,
  parameter int LA_W = 12,
  parameter int TAG_W = 6
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic resp_valid,
  input logic [1:0] resp_kind,
  input logic mem_req,
  input logic mem_we,
  input logic [LA_W-1:0] mem_addr,
  input logic mem_ack,
  input logic [SETS-1:0] l1_v,
  input logic [SETS-1:0][TAG_W-1:0] l1_tag,
  input logic [VB_ENTRIES-1:0] vb_v,
  input logic [VB_ENTRIES-1:0][LA_W-1:0] vb_la
);
  localparam int IDX_W = LA_W - TAG_W;
  logic overlap, dup;
  always_comb begin
    overlap = 1'b0;
    dup = 1'b0;
    for (int i = 0; i < VB_ENTRIES; i++) begin
      if (vb_v[i] && l1_v[vb_la[i][IDX_W-1:0]] &&
          l1_tag[vb_la[i][IDX_W-1:0]] == vb_la[i][LA_W-1:IDX_W]) overlap = 1'b1;
      for (int j = i + 1; j < VB_ENTRIES; j++)
        if (vb_v[i] && vb_v[j] && vb_la[i] == vb_la[j]) dup = 1'b1;
    end
  end

  // R6
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !overlap);
  // R6
  vb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R4
  swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_kind == 2'b10 |-> !$past(mem_req));
  // R11
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready && resp_kind != 2'b00);
  // R11
  busy_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

bind dm_victim_cache dm_victim_cache_chk #(
  .SETS(SETS), .VB_ENTRIES(VB_ENTRIES), .LA_W(LA_W), .TAG_W(TAG_W)
) chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_kind(resp_kind), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .l1_v(l1_v), .l1_tag(l1_tag), .vb_v(vb_v), .vb_la(vb_la)
);

// File: tb/dm_victim_cache_test.sv
module dm_victim_cache_test;
  localparam int PERIOD = 10;
  localparam int AW = 10, LW = 2, NS = 4, NV = 3;
  localparam int LAW = 7, LINEW = 64;
  localparam logic [9:0] JUNK = 10'd1020;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, resp_valid, mem_req, mem_we;
  logic [1:0] resp_kind;
  logic [31:0] resp_rdata;
  logic [LAW-1:0] mem_addr;
  logic [LINEW-1:0] mem_wdata, mem_rdata = '0;
  logic mem_ack = 0;

  dm_victim_cache #(.ADDR_W(AW), .LINE_WORDS(LW), .SETS(NS), .VB_ENTRIES(NV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata));

  always #(PERIOD/2) clk = ~clk;

  logic [LINEW-1:0] mem [128];
  logic [31:0] gold [256];
  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wb_cnt = 0, lat_cnt = 0, stamp = 0;
  logic [LAW-1:0] last_wb, last_rd;

  bit m_l1_v [NS]; int m_l1_la [NS]; bit m_l1_d [NS];
  bit m_vb_v [NV]; int m_vb_la [NV]; bit m_vb_d [NV]; int m_vb_st [NV];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(PERIOD*200000);
    chk(0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (lat_cnt == 0) begin
          if (mem_we) begin mem[mem_addr] = mem_wdata; wb_cnt++; last_wb = mem_addr; end
          else begin mem_rdata = mem[mem_addr]; rd_cnt++; last_rd = mem_addr; end
          mem_ack = 1;
          lat_cnt = $urandom_range(0, 2);
        end else lat_cnt--;
      end
    end
  end

  task automatic access(bit we, logic [9:0] a, logic [31:0] wd, logic [3:0] be, string req);
    int la, idx, kind, slot, lat, rd0, wb0;
    bit exp_wb, busy_bad;
    int wb_la;
    logic [31:0] w;
    la = int'(a[9:3]); idx = la % NS;
    exp_wb = 0; wb_la = 0; busy_bad = 0;
    w = gold[a[9:2]];
    if (we) for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = wd[8*b +: 8];
    gold[a[9:2]] = w;
    kind = 3;
    if (m_l1_v[idx] && m_l1_la[idx] == la) begin
      kind = 1; m_l1_d[idx] |= we;
    end else begin
      for (int j = 0; j < NV; j++)
        if (m_vb_v[j] && m_vb_la[j] == la) begin kind = 2; slot = j; end
      if (kind == 2) begin
        bit d;
        d = m_vb_d[slot];
        m_vb_la[slot] = m_l1_la[idx]; m_vb_d[slot] = m_l1_d[idx]; m_vb_st[slot] = ++stamp;
        m_l1_la[idx] = la; m_l1_d[idx] = d | we;
      end else begin
        if (m_l1_v[idx]) begin
          slot = -1;
          for (int j = 0; j < NV; j++) if (!m_vb_v[j] && slot < 0) slot = j;
          if (slot < 0) begin
            slot = 0;
            for (int j = 1; j < NV; j++) if (m_vb_st[j] < m_vb_st[slot]) slot = j;
            if (m_vb_d[slot]) begin exp_wb = 1; wb_la = m_vb_la[slot]; end
          end
          m_vb_v[slot] = 1; m_vb_la[slot] = m_l1_la[idx];
          m_vb_d[slot] = m_l1_d[idx]; m_vb_st[slot] = ++stamp;
        end
        m_l1_v[idx] = 1; m_l1_la[idx] = la; m_l1_d[idx] = we;
      end
    end
    rd0 = rd_cnt; wb0 = wb_cnt;
    @(negedge clk);
    chk(req_ready, "R11", "ready before request", {31'b0, req_ready}, 1);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!resp_valid && lat < 60) begin
      if (req_ready) busy_bad = 1;
      req_valid = 1; req_we = 1; req_addr = JUNK; req_wdata = 32'hDEAD_BEEF; req_be = 4'hF;
      @(negedge clk);
      lat++;
    end
    req_valid = 0;
    chk(resp_valid, req, "response arrived", lat, 0);
    if (lat > 1) chk(!busy_bad, "R11", "ready low while busy", busy_bad, 0);
    chk(resp_kind == 2'(kind), kind == 1 ? "R3" : kind == 2 ? "R4" : "R5",
        "resp_kind", resp_kind, kind);
    chk(resp_rdata == w, "R9", "read data", resp_rdata, w);
    if (kind == 1) chk(lat == 1, "R3", "hit latency", lat, 1);
    if (kind == 2) chk(lat == 2, "R4", "swap latency", lat, 2);
    if (kind != 3) chk(rd_cnt == rd0 && wb_cnt == wb0, kind == 1 ? "R3" : "R4",
                       "memory quiet", rd_cnt - rd0 + wb_cnt - wb0, 0);
    else begin
      chk(rd_cnt == rd0 + 1 && last_rd == 7'(la), "R10", "fill address", last_rd, la);
      chk(wb_cnt == wb0 + int'(exp_wb), "R8", "write-back count", wb_cnt - wb0, exp_wb);
      if (exp_wb) chk(last_wb == 7'(wb_la), "R7", "LRU write-back line", last_wb, wb_la);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) gold[i] = (32'h9E37_79B9 * (i + 1)) ^ i;
    for (int l = 0; l < 128; l++) mem[l] = {gold[2*l+1], gold[2*l]};
    for (int i = 0; i < NS; i++) begin m_l1_v[i] = 0; m_l1_d[i] = 0; m_l1_la[i] = 0; end
    for (int i = 0; i < NV; i++) begin m_vb_v[i] = 0; m_vb_d[i] = 0; m_vb_la[i] = 0; m_vb_st[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1", "reset outputs",
        {req_ready, resp_valid, mem_req}, 3'b100);
    rst_n = 1;
    // directed: idx 0 lines A (la 0) and B (la 4)
    access(0, 10'h000, 0, 0, "R1");
    access(0, 10'h004, 0, 0, "R3");
    access(1, 10'h004, 32'h1122_3344, 4'b0101, "R9");
    access(0, 10'h020, 0, 0, "R2");
    access(0, 10'h004, 0, 0, "R4");
    access(0, 10'h020, 0, 0, "R6");
    // fill idx 1 with dirty lines to force LRU write-backs
    for (int t = 0; t < 6; t++) access(1, 10'((t << 5) | 8), 32'hA5A5_0000 + t, 4'hF, "R8");
    for (int t = 0; t < 6; t++) access(0, 10'((t << 5) | 8), 0, 0, "R7");
    // random phase over 16 lines
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] a;
      a = {3'b0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 2'b00};
      access(1'($urandom_range(0, 1)), a, $urandom, 4'($urandom_range(0, 15)), "R9");
    end
    // junk writes while busy must have left this word untouched
    access(0, JUNK, 0, 0, "R11");
    finish_run();
  end
endmodule